// File: doc/BRIEF.md
# Segmented Address Translation Checker

This block turns a segment choice and a 32-bit offset into a linear address, and it checks the access in the same cycle. A mode bit picks one of two paths. The legacy path multiplies a 16-bit segment value by sixteen and adds the offset. The result is only legal while it fits in 20 bits. The protected path adds the offset to a 32-bit segment base held in a small on-block descriptor cache. It then tests the sum against the cached limit and the segment's access rights. The result is either an address that may be issued or a fault code that says why it was refused.

Six segment slots live in the cache. A load port fills one slot at a time with a legacy segment value, a base, a limit and two rights bits (writable, fetch-only). Every request gets exactly one registered response on the next cycle. An instruction fetch always goes through the code slot (slot 0), whatever the segment input says.

Top module: `seg_xlate`

## Requirements
- R1: After reset, every response output is zero. Each of the six slots holds segment value 0, base 0 and limit 0xFFFFFFFF, is writable and is not fetch-only.
- R2: A request sampled at one rising edge produces `rsp_ack` high for exactly the following cycle. With no request, `rsp_ack`, `rsp_ok` and `rsp_fault` are all zero.
- R3: In legacy mode (`req_prot`=0), the address is segment value × 16 plus offset, zero-extended to 32 bits. Limits and rights are not checked in this mode.
- R4: In legacy mode, if segment value × 16 plus offset does not fit in 20 bits, the response carries fault code 4.
- R5: In protected mode, the address is slot base plus offset, taken modulo 2^32.
- R6: In protected mode, the access gets fault code 1 when base plus offset, with the carry counted, is greater than the slot limit. A slot with base 0 and limit 0xFFFFFFFF never gets this fault.
- R7: In protected mode, a write (`req_kind`=01) to a slot that is not writable gets fault code 2.
- R8: In protected mode, a data read (`req_kind`=00 or 11) or a write to a fetch-only slot gets fault code 3.
- R9: A fetch (`req_kind`=10) always uses slot 0 and ignores `req_seg`.
- R10: A read or write whose `req_seg` is 6 or 7 gets fault code 5, in either mode.
- R11: Whenever the fault code is nonzero, `rsp_ok` is low and `rsp_addr` is zero. When `rsp_ok` is high, the fault code is zero.
- R12: When more than one fault applies, the code shown follows this priority: 5, then 3, then 2, then 1.
- R13: A slot load takes effect for requests sampled from the next edge on. A request sampled in the same cycle as the load sees the old contents. A load with `ld_idx` 6 or 7 changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write one cache slot |
| ld_idx | input | 3 | Slot to write |
| ld_sel | input | 16 | Legacy segment value for the slot |
| ld_base | input | 32 | Protected segment base |
| ld_limit | input | 32 | Protected segment limit (highest legal address) |
| ld_writable | input | 1 | Slot accepts writes |
| ld_xonly | input | 1 | Slot is fetch-only |
| req_valid | input | 1 | Translation request |
| req_prot | input | 1 | 1 = protected path, 0 = legacy path |
| req_seg | input | 3 | Segment slot for data accesses |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| req_offset | input | 32 | Offset within the segment |
| rsp_ack | output | 1 | Response present |
| rsp_ok | output | 1 | Address may be issued |
| rsp_addr | output | 32 | Linear address (zero on fault) |
| rsp_fault | output | 3 | 0 none, 1 limit, 2 read-only write, 3 fetch-only data, 4 legacy range, 5 bad segment |

## Verification
The hardest cases to reach are those where several faults apply at once, or where a slot load and a request share an edge. The bench reaches them by setting up slots that break more than one rule together. Examples are a read-only slot whose limit is also exceeded, and a fetch-only slot hit by a write. It also issues a load and a request in the same cycle, so the expected result must come from the slot's contents before the load. A base near the top of the address space, paired with a large offset, drives the carry path of the limit compare.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_FETCH = 2'b10,
    KIND_READ2 = 2'b11
  } kind_e;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_LIMIT  = 3'd1,
    FLT_RDONLY = 3'd2,
    FLT_XONLY  = 3'd3,
    FLT_LEGACY = 3'd4,
    FLT_BADSEG = 3'd5
  } fault_e;

endpackage

// File: rtl/seg_xlate_cache.sv
module seg_xlate_cache #(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16,
  parameter int NSEG   = 6,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [ADDR_W-1:0] wr_limit,
  input  logic              wr_writable,
  input  logic              wr_xonly,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [SEL_W-1:0]  rd_sel,
  output logic [ADDR_W-1:0] rd_base,
  output logic [ADDR_W-1:0] rd_limit,
  output logic              rd_writable,
  output logic              rd_xonly
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSEG - 1);

  logic [SEL_W-1:0]  sel_q   [NSEG];
  logic [ADDR_W-1:0] base_q  [NSEG];
  logic [ADDR_W-1:0] limit_q [NSEG];
  logic              wr_q    [NSEG];
  logic              xo_q    [NSEG];

  // one register slot per segment, reset to a flat writable segment
  for (genvar i = 0; i < NSEG; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        sel_q[i]   <= '0;
        base_q[i]  <= '0;
        limit_q[i] <= '1;
        wr_q[i]    <= 1'b1;
        xo_q[i]    <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(i))) begin
        sel_q[i]   <= wr_sel;
        base_q[i]  <= wr_base;
        limit_q[i] <= wr_limit;
        wr_q[i]    <= wr_writable;
        xo_q[i]    <= wr_xonly;
      end
    end
  end

  logic [IDX_W-1:0] rd_safe;
  assign rd_safe = (rd_idx <= LAST_IDX) ? rd_idx : '0;

  always_comb begin
    rd_sel      = sel_q[rd_safe];
    rd_base     = base_q[rd_safe];
    rd_limit    = limit_q[rd_safe];
    rd_writable = wr_q[rd_safe];
    rd_xonly    = xo_q[rd_safe];
  end

endmodule

// File: rtl/seg_xlate_legacy.sv
module seg_xlate_legacy #(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16,
  parameter int LEG_W  = 20,
  parameter int SHIFT  = 4
) (
  input  logic [SEL_W-1:0]  seg_val,
  input  logic [ADDR_W-1:0] offset,
  output logic [ADDR_W-1:0] addr,
  output logic              range_flt
);

  localparam int SUM_W = ADDR_W + 1;

  logic [SUM_W-1:0] seg_ext;
  logic [SUM_W-1:0] sum;

  assign seg_ext   = {{(SUM_W - SEL_W){1'b0}}, seg_val} << SHIFT;
  assign sum       = seg_ext + {1'b0, offset};
  assign range_flt = |sum[SUM_W-1:LEG_W];
  assign addr      = {{(ADDR_W - LEG_W){1'b0}}, sum[LEG_W-1:0]};

endmodule

// File: rtl/seg_xlate_prot.sv
module seg_xlate_prot
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  input  logic              writable,
  input  logic              xonly,
  input  kind_e             kind,
  input  logic [ADDR_W-1:0] offset,
  output logic [ADDR_W-1:0] addr,
  output fault_e            fault
);

  logic [ADDR_W:0] sum;
  logic            over;
  logic            is_data;

  assign sum     = {1'b0, base} + {1'b0, offset};
  assign over    = sum > {1'b0, limit};
  assign is_data = (kind != KIND_FETCH);
  assign addr    = sum[ADDR_W-1:0];

  // rights faults outrank the limit compare
  always_comb begin
    if (xonly && is_data)                 fault = FLT_XONLY;
    else if (kind == KIND_WRITE && !writable) fault = FLT_RDONLY;
    else if (over)                        fault = FLT_LIMIT;
    else                                  fault = FLT_NONE;
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16,
  parameter int LEG_W  = 20,
  parameter int SHIFT  = 4,
  parameter int NSEG   = 6,
  parameter int IDX_W  = 3,
  parameter int FLT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [ADDR_W-1:0] ld_base,
  input  logic [ADDR_W-1:0] ld_limit,
  input  logic              ld_writable,
  input  logic              ld_xonly,
  input  logic              req_valid,
  input  logic              req_prot,
  input  logic [IDX_W-1:0]  req_seg,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_offset,
  output logic              rsp_ack,
  output logic              rsp_ok,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [FLT_W-1:0]  rsp_fault
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSEG - 1);
  localparam logic [IDX_W-1:0] CODE_IDX = '0;

  kind_e            kind;
  logic [IDX_W-1:0] eff_idx;
  logic             bad_seg;

  assign kind    = kind_e'(req_kind);
  assign eff_idx = (kind == KIND_FETCH) ? CODE_IDX : req_seg;
  assign bad_seg = eff_idx > LAST_IDX;

  logic [SEL_W-1:0]  c_sel;
  logic [ADDR_W-1:0] c_base;
  logic [ADDR_W-1:0] c_limit;
  logic              c_wr;
  logic              c_xo;

  seg_xlate_cache #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .NSEG(NSEG), .IDX_W(IDX_W)
  ) u_cache (
    .clk(clk), .rst(rst),
    .wr_en(ld_en), .wr_idx(ld_idx), .wr_sel(ld_sel), .wr_base(ld_base),
    .wr_limit(ld_limit), .wr_writable(ld_writable), .wr_xonly(ld_xonly),
    .rd_idx(eff_idx), .rd_sel(c_sel), .rd_base(c_base), .rd_limit(c_limit),
    .rd_writable(c_wr), .rd_xonly(c_xo)
  );

  logic [ADDR_W-1:0] leg_addr;
  logic              leg_flt;

  seg_xlate_legacy #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .LEG_W(LEG_W), .SHIFT(SHIFT)
  ) u_legacy (
    .seg_val(c_sel), .offset(req_offset), .addr(leg_addr), .range_flt(leg_flt)
  );

  logic [ADDR_W-1:0] pm_addr;
  fault_e            pm_fault;

  seg_xlate_prot #(.ADDR_W(ADDR_W)) u_prot (
    .base(c_base), .limit(c_limit), .writable(c_wr), .xonly(c_xo),
    .kind(kind), .offset(req_offset), .addr(pm_addr), .fault(pm_fault)
  );

  fault_e            fault_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    if (bad_seg)       fault_d = FLT_BADSEG;
    else if (req_prot) fault_d = pm_fault;
    else if (leg_flt)  fault_d = FLT_LEGACY;
    else               fault_d = FLT_NONE;
    addr_d = req_prot ? pm_addr : leg_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_ack   <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_addr  <= '0;
      rsp_fault <= '0;
    end else begin
      rsp_ack   <= req_valid;
      rsp_ok    <= req_valid && (fault_d == FLT_NONE);
      rsp_addr  <= (req_valid && fault_d == FLT_NONE) ? addr_d : '0;
      rsp_fault <= req_valid ? FLT_W'(fault_d) : '0;
    end
  end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int ADDR_W = 32,
  parameter int LEG_W  = 20,
  parameter int FLT_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_prot,
  input logic [1:0]        req_kind,
  input logic              rsp_ack,
  input logic              rsp_ok,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic [FLT_W-1:0]  rsp_fault
);

  assert_ack_latency_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_ack == ($past(req_valid) && !$past(rst)));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !rsp_ack |-> (!rsp_ok && rsp_fault == '0));

  assert_fault_blocks_R11: assert property (@(posedge clk) disable iff (rst)
    (rsp_fault != '0) |-> (!rsp_ok && rsp_addr == '0));

  assert_legacy_width_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_ok && !$past(req_prot)) |-> (rsp_addr[ADDR_W-1:LEG_W] == '0));

  assert_legacy_codes_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_ack && !$past(req_prot)) |->
      (rsp_fault == 3'd0 || rsp_fault == 3'd4 || rsp_fault == 3'd5));

  assert_fetch_slot_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_ack && $past(req_kind) == 2'b10) |-> (rsp_fault != 3'd5));

endmodule

bind seg_xlate seg_xlate_chk #(.ADDR_W(ADDR_W), .LEG_W(LEG_W), .FLT_W(FLT_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_prot(req_prot),
  .req_kind(req_kind), .rsp_ack(rsp_ack), .rsp_ok(rsp_ok),
  .rsp_addr(rsp_addr), .rsp_fault(rsp_fault)
);

// File: tb/sim_seg_xlate.sv
`timescale 1ns/1ps
module sim_seg_xlate;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_idx = '0;
  logic [15:0] ld_sel = '0;
  logic [31:0] ld_base = '0;
  logic [31:0] ld_limit = '0;
  logic        ld_writable = 1'b0;
  logic        ld_xonly = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_prot = 1'b0;
  logic [2:0]  req_seg = '0;
  logic [1:0]  req_kind = '0;
  logic [31:0] req_offset = '0;
  logic        rsp_ack, rsp_ok;
  logic [31:0] rsp_addr;
  logic [2:0]  rsp_fault;

  always #2.5 clk = ~clk;

  seg_xlate u0 (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_idx(ld_idx), .ld_sel(ld_sel),
    .ld_base(ld_base), .ld_limit(ld_limit), .ld_writable(ld_writable),
    .ld_xonly(ld_xonly), .req_valid(req_valid), .req_prot(req_prot),
    .req_seg(req_seg), .req_kind(req_kind), .req_offset(req_offset),
    .rsp_ack(rsp_ack), .rsp_ok(rsp_ok), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault)
  );

  typedef struct {
    logic        ok;
    logic [31:0] addr;
    logic [2:0]  flt;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   errors = 0;
  int   checks = 0;
  bit   done = 0;

  // bench-side mirror of the six slots
  logic [15:0] m_sel  [6];
  logic [31:0] m_base [6];
  logic [31:0] m_lim  [6];
  logic        m_wr   [6];
  logic        m_xo   [6];

  function automatic exp_t model(bit prot, logic [2:0] seg, logic [1:0] kind,
                                 logic [31:0] off, string tag);
    exp_t e;
    int idx;
    logic [32:0] s;
    e.tag = tag; e.ok = 0; e.addr = '0; e.flt = 3'd0;
    idx = (kind == 2'b10) ? 0 : int'(seg);
    if (idx > 5) begin e.flt = 3'd5; return e; end
    if (!prot) begin
      s = {17'b0, m_sel[idx]} * 33'd16 + {1'b0, off};
      if (s >= 33'h100000) e.flt = 3'd4;
      else begin e.ok = 1; e.addr = s[31:0]; end
    end else begin
      if (m_xo[idx] && kind != 2'b10) e.flt = 3'd3;
      else if (kind == 2'b01 && !m_wr[idx]) e.flt = 3'd2;
      else begin
        s = {1'b0, m_base[idx]} + {1'b0, off};
        if (s > {1'b0, m_lim[idx]}) e.flt = 3'd1;
        else begin e.ok = 1; e.addr = s[31:0]; end
      end
    end
    return e;
  endfunction

  task automatic check(bit cond, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, expv);
    end
  endtask

  task automatic drive_req(bit prot, logic [2:0] seg, logic [1:0] kind,
                           logic [31:0] off);
    req_valid = 1; req_prot = prot; req_seg = seg; req_kind = kind; req_offset = off;
  endtask

  task automatic mirror(logic [2:0] idx, logic [15:0] sel, logic [31:0] base,
                        logic [31:0] lim, bit wr, bit xo);
    ld_en = 1; ld_idx = idx; ld_sel = sel; ld_base = base; ld_limit = lim;
    ld_writable = wr; ld_xonly = xo;
    if (idx < 6) begin
      m_sel[idx] = sel; m_base[idx] = base; m_lim[idx] = lim;
      m_wr[idx] = wr; m_xo[idx] = xo;
    end
  endtask

  task automatic issue(bit prot, logic [2:0] seg, logic [1:0] kind,
                       logic [31:0] off, string tag);
    @(negedge clk);
    ld_en = 0;
    drive_req(prot, seg, kind, off);
    sb.push_back(model(prot, seg, kind, off, tag));
  endtask

  task automatic load(logic [2:0] idx, logic [15:0] sel, logic [31:0] base,
                      logic [31:0] lim, bit wr, bit xo);
    @(negedge clk);
    req_valid = 0;
    mirror(idx, sel, base, lim, wr, xo);
  endtask

  // request and load in one cycle: the request must see the old slot
  task automatic load_and_issue(logic [2:0] idx, logic [15:0] sel, logic [31:0] base,
                                logic [31:0] lim, bit wr, bit xo, bit prot,
                                logic [2:0] seg, logic [1:0] kind,
                                logic [31:0] off, string tag);
    @(negedge clk);
    drive_req(prot, seg, kind, off);
    sb.push_back(model(prot, seg, kind, off, tag));
    mirror(idx, sel, base, lim, wr, xo);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0; ld_en = 0;
    end
  endtask

  // monitor: pop and compare each response
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rsp_ack) begin
        if (sb.size() == 0) begin
          check(0, "R2 response without request", 64'(rsp_ack), 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(rsp_ok == e.ok && rsp_addr == e.addr && rsp_fault == e.flt, e.tag,
                {28'd0, rsp_ok, rsp_fault, rsp_addr}, {28'd0, e.ok, e.flt, e.addr});
        end
      end else begin
        check(!rsp_ok && rsp_fault == 0, "R2 idle outputs quiet",
              {60'd0, rsp_ok, rsp_fault}, 64'd0);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 6; i++) begin
      m_sel[i] = '0; m_base[i] = '0; m_lim[i] = '1; m_wr[i] = 1; m_xo[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!rsp_ack && !rsp_ok && rsp_addr == 0 && rsp_fault == 0, "R1 reset outputs",
          {30'd0, rsp_ack, rsp_ok, rsp_addr}, 64'd0);

    // R1: default slots are flat and writable
    for (int s = 0; s < 6; s++) begin
      issue(1, 3'(s), 2'b01, 32'hFFFF_FFFF, "R1 R6 flat default write");
      issue(0, 3'(s), 2'b00, 32'h0000_1234, "R1 R3 default legacy");
    end

    // R3 / R4 legacy path
    load(3'd1, 16'hF000, 32'h0, 32'h0, 0, 0);
    issue(0, 3'd1, 2'b00, 32'h0000_FFFF, "R3 legacy top of range");
    issue(0, 3'd1, 2'b00, 32'h0001_0000, "R4 legacy over 20 bits");
    issue(0, 3'd1, 2'b01, 32'h0000_0010, "R3 legacy ignores rights");
    issue(0, 3'd1, 2'b00, 32'h8000_0000, "R4 legacy wide offset");
    load(3'd2, 16'h1234, 32'h0, 32'h0, 1, 0);
    issue(0, 3'd2, 2'b11, 32'h0000_0005, "R3 legacy read code 11");

    // R5 / R6 protected path
    load(3'd3, 16'h0, 32'h0000_1000, 32'h0000_1FFF, 1, 0);
    issue(1, 3'd3, 2'b00, 32'h0000_0FFF, "R5 protected at limit");
    issue(1, 3'd3, 2'b00, 32'h0000_1000, "R6 one past limit");
    issue(1, 3'd3, 2'b01, 32'h0000_0000, "R5 protected write ok");
    load(3'd4, 16'h0, 32'hFFFF_F000, 32'hFFFF_FFFF, 1, 0);
    issue(1, 3'd4, 2'b00, 32'h0000_0FFF, "R5 high base at top");
    issue(1, 3'd4, 2'b00, 32'h0000_2000, "R6 carry out exceeds limit");

    // R7 read-only
    load(3'd5, 16'h0, 32'h0010_0000, 32'h0010_00FF, 0, 0);
    issue(1, 3'd5, 2'b01, 32'h0000_0010, "R7 write to read-only");
    issue(1, 3'd5, 2'b00, 32'h0000_0010, "R7 read of read-only ok");
    issue(1, 3'd5, 2'b01, 32'h0000_1000, "R12 read-only over limit");

    // R8 / R9 fetch-only code slot
    load(3'd0, 16'h0800, 32'h0020_0000, 32'h0020_FFFF, 0, 1);
    issue(1, 3'd3, 2'b10, 32'h0000_0100, "R9 fetch uses slot 0");
    issue(1, 3'd7, 2'b10, 32'h0000_0200, "R9 fetch ignores bad seg");
    issue(1, 3'd0, 2'b00, 32'h0000_0100, "R8 read of fetch-only");
    issue(1, 3'd0, 2'b11, 32'h0000_0100, "R8 read code 11 of fetch-only");
    issue(1, 3'd0, 2'b01, 32'h0001_0000, "R12 write fetch-only over limit");
    issue(1, 3'd0, 2'b10, 32'h0001_0000, "R6 fetch past limit");
    issue(0, 3'd5, 2'b10, 32'h0000_0004, "R9 legacy fetch uses slot 0");

    // R10 bad segment
    issue(1, 3'd6, 2'b00, 32'h0, "R10 seg 6 read");
    issue(0, 3'd7, 2'b01, 32'h0, "R10 seg 7 legacy write");
    issue(1, 3'd6, 2'b01, 32'hFFFF_FFFF, "R12 bad seg outranks");

    // R13 load ordering and ignored indices
    load_and_issue(3'd3, 16'h0, 32'h4000_0000, 32'h4000_0FFF, 1, 0,
                   1, 3'd3, 2'b00, 32'h0000_0010, "R13 same-cycle sees old");
    issue(1, 3'd3, 2'b00, 32'h0000_0010, "R13 next cycle sees new");
    load(3'd7, 16'hAAAA, 32'hABC0_0000, 32'h0000_0010, 0, 1);
    load(3'd6, 16'h5555, 32'h1230_0000, 32'h0000_0010, 0, 1);
    for (int s = 0; s < 6; s++) begin
      issue(1, 3'(s), 2'b00, 32'h0000_0010, "R13 ignored index changes nothing");
      issue(0, 3'(s), 2'b00, 32'h0000_0010, "R13 ignored index legacy view");
    end

    idle(4);
    check(sb.size() == 0, "R2 all responses seen", 64'(sb.size()), 64'd0);
    finish_run();
  end

endmodule